// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block holds the configuration of one phase-locked loop as four 32-bit words on a simple single-cycle bus. Three of the words use a write-enable-per-bit convention: the upper half of every written word selects which bits of the lower half may change. Software can then update one field without first reading the word back. The fourth word carries the fractional multiplier value and is written as an ordinary full word. Its top bit reports whether the loop has locked.

The bank drives the loop with decoded fields: the feedback divider, the reference divider, two post dividers, the fractional value, power-down and fractional-mode disable. The analog loop is outside this block. Its lock indication enters on one asynchronous input, passes through a synchronizer and is read back through the bus.

Top module: `pllcfg_bank`

## Requirements
- R1: After reset, power_down is 1. Every other decoded field is 0, and every register reads 0 except word 3, which reads 0x00000001.
- R2: In words 0, 1 and 3, a write changes bit i of [15:0] only when bit 16+i of the written word is 1. The bit then takes the written value. Every other bit keeps its value.
- R3: Words 0, 1 and 3 read 0 in bits [31:16]. Bits of [15:0] that hold no field also read 0.
- R4: Word 0 (byte offset 0x0) holds the 12-bit feedback divider in bits [11:0], driven on fb_div.
- R5: Word 1 (byte offset 0x4) holds the reference divider in [5:0], the first post divider in [10:8] and the second post divider in [14:12]. These drive ref_div, post_div1 and post_div2.
- R6: Word 2 (byte offset 0x8) is written as a full word. Bits [23:0] become frac_val, whatever the upper half holds. Bits [30:24] ignore writes and read 0.
- R7: Bit 31 of word 2 ignores writes and reads the lock input delayed by the synchronizer. With SYNC_STAGES=2, a change on pll_lock_in is visible after the second rising edge and not after the first. It also drives lock_seen.
- R8: Word 3 (byte offset 0xC) holds power-down in bit 0 and the fractional-mode disable in bit 3, driven on power_down and frac_off.
- R9: When bus_wr is 0, no register changes.
- R10: An access whose address bits [1:0] are not zero changes no register and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pll_lock_in | input | 1 | Asynchronous lock indication from the loop |
| fb_div | output | 12 | Feedback divider |
| ref_div | output | 6 | Reference divider |
| post_div1 | output | 3 | First post divider |
| post_div2 | output | 3 | Second post divider |
| frac_val | output | FRAC_W (24) | Fractional multiplier value |
| power_down | output | 1 | Loop power-down |
| frac_off | output | 1 | Fractional mode disabled |
| lock_seen | output | 1 | Synchronized lock indication |

## Verification
The bench builds the block with its default parameters: a 4-bit address, a 24-bit fractional field and a two-stage synchronizer. With these values every enable bit of every masked word can be swept one at a time, with both written values, and then crossed with a series of dense mixed-enable patterns. It also puts the exact two-edge lock latency within reach, so both the "not yet" and the "now visible" cycles can be checked.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

  localparam int REG_W  = 32;
  localparam int HALF_W = 16;

  localparam int FB_W   = 12;
  localparam int REF_W  = 6;
  localparam int POST_W = 3;

  localparam int REF_LSB     = 0;
  localparam int POST1_LSB   = 8;
  localparam int POST2_LSB   = 12;
  localparam int PD_BIT      = 0;
  localparam int FRACOFF_BIT = 3;

  typedef enum logic [1:0] {
    SEL_FB      = 2'd0,
    SEL_REFPOST = 2'd1,
    SEL_FRAC    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  // Bits of the low half that hold a field, per word index.
  function automatic logic [HALF_W-1:0] impl_of(input int idx);
    case (idx)
      0:       impl_of = 16'h0FFF;
      1:       impl_of = 16'h773F;
      3:       impl_of = 16'h0009;
      default: impl_of = 16'h0000;
    endcase
  endfunction

  // Reset contents per word index: only power-down starts set.
  function automatic logic [HALF_W-1:0] reset_of(input int idx);
    reset_of = (idx == 3) ? 16'h0001 : 16'h0000;
  endfunction

  // New low half after a write with per-bit enables in the upper half.
  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_val,
    input logic [REG_W-1:0]  word,
    input logic [HALF_W-1:0] impl
  );
    logic [HALF_W-1:0] en;
    en = word[REG_W-1:HALF_W];
    masked_merge = ((old_val & ~en) | (word[HALF_W-1:0] & en)) & impl;
  endfunction

endpackage

// File: rtl/pllcfg_mask_reg.sv
module pllcfg_mask_reg
  import pllcfg_pkg::*;
#(
  parameter logic [15:0] IMPL      = 16'hFFFF,
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [REG_W-1:0]    wdata,
  output logic [HALF_W-1:0]   q
);

  logic [HALF_W-1:0] next_q;

  always_comb next_q = masked_merge(q, wdata, IMPL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RESET_VAL & IMPL;
    else if (wr_hit) q <= next_q;
  end

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (((q ^ $past(q)) & ~$past(wdata[REG_W-1:HALF_W])) == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q)); // R9

endmodule

// File: rtl/pllcfg_frac_reg.sv
module pllcfg_frac_reg #(
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [FRAC_W-1:0] wdata,
  output logic [FRAC_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= wdata;
  end

  AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q)); // R6

endmodule

// File: rtl/pllcfg_lock_sync.sv
module pllcfg_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pllcfg_bank.sv
module pllcfg_bank
  import pllcfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int FRAC_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic               pll_lock_in,
  output logic [FB_W-1:0]    fb_div,
  output logic [REF_W-1:0]   ref_div,
  output logic [POST_W-1:0]  post_div1,
  output logic [POST_W-1:0]  post_div2,
  output logic [FRAC_W-1:0]  frac_val,
  output logic               power_down,
  output logic               frac_off
  ,
  output logic               lock_seen
);

  localparam int NUM_REGS = 4;
  localparam int FRAC_PAD = REG_W - 1 - FRAC_W;

  reg_sel_e          sel;
  logic              aligned;
  logic [NUM_REGS-1:0] wr_hit;
  logic [HALF_W-1:0] mreg_q [NUM_REGS];
  logic [FRAC_W-1:0] frac_q;
  logic              lock_sync;

  // Word select and alignment; named for the assertions.
  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    wr_hit = '0;
    if (bus_wr && aligned) wr_hit[sel] = 1'b1;
  end

  // Masked words generated from the per-index field maps.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    if (g == int'(SEL_FRAC)) begin : g_plain
      assign mreg_q[g] = '0;
    end else begin : g_masked
      pllcfg_mask_reg #(
        .IMPL      (impl_of(g)),
        .RESET_VAL (reset_of(g))
      ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit[g]),
        .wdata  (bus_wdata),
        .q      (mreg_q[g])
      );
    end
  end

  pllcfg_frac_reg #(.FRAC_W(FRAC_W)) u_frac (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit[SEL_FRAC]),
    .wdata  (bus_wdata[FRAC_W-1:0]),
    .q      (frac_q)
  );

  pllcfg_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pll_lock_in),
    .sync_out (lock_sync)
  );

  // Read path.
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (sel == SEL_FRAC) bus_rdata = {lock_sync, {FRAC_PAD{1'b0}}, frac_q};
      else                 bus_rdata = {{HALF_W{1'b0}}, mreg_q[sel]};
    end
  end

  // Field decode.
  assign fb_div     = mreg_q[SEL_FB][FB_W-1:0];
  assign ref_div    = mreg_q[SEL_REFPOST][REF_LSB +: REF_W];
  assign post_div1  = mreg_q[SEL_REFPOST][POST1_LSB +: POST_W];
  assign post_div2  = mreg_q[SEL_REFPOST][POST2_LSB +: POST_W];
  assign frac_val   = frac_q;
  assign power_down = mreg_q[SEL_CTRL][PD_BIT];
  assign frac_off   = mreg_q[SEL_CTRL][FRACOFF_BIT];
  assign lock_seen  = lock_sync;

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_FRAC) |-> (bus_rdata[REG_W-1:HALF_W] == '0)); // R3

  AST_PD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[SEL_CTRL] && bus_wdata[HALF_W+PD_BIT]) |=> (power_down == $past(bus_wdata[PD_BIT]))); // R8

  AST_MISALIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (bus_rdata == '0)); // R10

endmodule

// File: tb/tb_pllcfg_bank.sv
module tb_pllcfg_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_lock_in = 1'b0;
  logic [11:0] fb_div;
  logic [5:0]  ref_div;
  logic [2:0]  post_div1, post_div2;
  logic [23:0] frac_val;
  logic        power_down, frac_off, lock_seen;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // Expected state, kept by the bench.
  logic [15:0] m0, m1, m3;
  logic [23:0] mf;
  logic        lk;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllcfg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock_in(pll_lock_in),
    .fb_div(fb_div), .ref_div(ref_div), .post_div1(post_div1),
    .post_div2(post_div2), .frac_val(frac_val), .power_down(power_down),
    .frac_off(frac_off), .lock_seen(lock_seen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench's own statement of the write rule.
  function automatic logic [15:0] apply(input logic [15:0] old_v, input logic [31:0] w,
                                        input logic [15:0] fields);
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = w[16+i] ? w[i] : old_v[i];
    return r & fields;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit strobe);
    @(negedge clk);
    bus_wr = strobe; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (strobe && a[1:0] == 2'b00) begin
      case (a[3:2])
        2'd0: m0 = apply(m0, d, 16'h0FFF);
        2'd1: m1 = apply(m1, d, 16'h773F);
        2'd2: mf = d[23:0];
        default: m3 = apply(m3, d, 16'h0009);
      endcase
    end
  endtask

  task automatic check_all(input string tag);
    bus_addr = 4'h0; #1; chk({tag, " R2 R3 R4 word0"}, bus_rdata, {16'h0, m0});
    bus_addr = 4'h4; #1; chk({tag, " R2 R3 R5 word1"}, bus_rdata, {16'h0, m1});
    bus_addr = 4'h8; #1; chk({tag, " R6 R7 word2"}, bus_rdata, {lk, 7'h0, mf});
    bus_addr = 4'hC; #1; chk({tag, " R2 R3 R8 word3"}, bus_rdata, {16'h0, m3});
    chk({tag, " R4 fb_div"}, 32'(fb_div), 32'(m0[11:0]));
    chk({tag, " R5 ref_div"}, 32'(ref_div), 32'(m1[5:0]));
    chk({tag, " R5 post_div1"}, 32'(post_div1), 32'(m1[10:8]));
    chk({tag, " R5 post_div2"}, 32'(post_div2), 32'(m1[14:12]));
    chk({tag, " R6 frac_val"}, 32'(frac_val), 32'(mf));
    chk({tag, " R8 power_down"}, 32'(power_down), 32'(m3[0]));
    chk({tag, " R8 frac_off"}, 32'(frac_off), 32'(m3[3]));
    chk({tag, " R7 lock_seen"}, 32'(lock_seen), 32'(lk));
  endtask

  initial begin
    m0 = '0; m1 = '0; m3 = 16'h0001; mf = '0; lk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // One enable bit at a time, both written values, every masked word.
    for (int w = 0; w < 3; w++) begin
      for (int b = 0; b < 16; b++) begin
        for (int v = 0; v < 2; v++) begin
          logic [3:0] a;
          a = (w == 2) ? 4'hC : 4'(w * 4);
          wr(a, {16'(1 << b), (v != 0) ? 16'hFFFF : 16'h0000}, 1'b1);
          check_all("R2 single-bit sweep");
        end
      end
    end

    // Mixed enable and data patterns.
    for (int p = 0; p < 32; p++) begin
      logic [15:0] en, dt;
      en = 16'(p * 16'h6D2B + 16'h0101);
      dt = 16'(p * 16'h9E37 + 16'h5A5A);
      wr(4'h0, {en, dt}, 1'b1);
      wr(4'h4, {en, dt}, 1'b1);
      wr(4'hC, {en, dt}, 1'b1);
      wr(4'h8, {en, dt}, 1'b1);
      check_all("R2 R6 mixed pattern");
    end

    // Strobe low: nothing moves.
    wr(4'h0, 32'hFFFF_FFFF, 1'b0);
    wr(4'h4, 32'hFFFF_0000, 1'b0);
    wr(4'h8, 32'h00AB_CDEF, 1'b0);
    check_all("R9 no strobe");

    // Misaligned accesses: ignored, read 0.
    wr(4'h1, 32'hFFFF_FFFF, 1'b1);
    wr(4'hE, 32'hFFFF_FFFF, 1'b1);
    check_all("R10 misaligned write");
    bus_addr = 4'h5; #1; chk("R10 misaligned read", bus_rdata, 32'h0);

    // Full-word frac write with the top bits set.
    wr(4'h8, 32'hFFFF_FFFF, 1'b1);
    check_all("R6 R7 frac all ones");
    wr(4'h8, 32'h8012_3456, 1'b1);
    check_all("R6 frac value");

    // Lock latency: invisible after one edge, visible after two.
    @(negedge clk); pll_lock_in = 1'b1;
    @(negedge clk);
    chk("R7 lock after one edge", 32'(lock_seen), 32'h0);
    @(negedge clk);
    lk = 1'b1;
    check_all("R7 lock after two edges");
    wr(4'h8, 32'h0000_0077, 1'b1);
    check_all("R7 write keeps lock bit");
    @(negedge clk); pll_lock_in = 1'b0;
    @(negedge clk);
    chk("R7 unlock after one edge", 32'(lock_seen), 32'h1);
    @(negedge clk);
    lk = 1'b0;
    check_all("R7 unlock after two edges");

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule